// File: doc/BRIEF.md
# CPU Run-State Sequencing Controller

This block decides when a processor core may execute. It holds one of four run states (stopped, operating, loading, check-stopped) and moves between them on operator keys, on the rate-control setting, and on status reported by the execution core. The core receives a run enable and a request to take interruptions. The block does not perform the interruption itself.

A stop request never cuts an instruction in half. It waits for the core to report the end of a unit of operation. If the core sits in the wait state, the stop takes effect at once. In both cases every enabled interruption that is still pending is taken first. With rate control set to instruction step, a start runs exactly one unit and then stops. If the wait bit is set at that start, no instruction runs: only the pending interruptions are taken before the core stops again.

The load keys start an initial program load. When the load completes, the block goes to operating in process mode or to stopped in step mode. A machine malfunction locks the block in check-stop, and only a completed reset releases it.

Top module: `cpu_run_ctrl`

## Requirements
- R1: While rst_n is low and right after it rises, state is 00 (stopped), and run_en, irq_take, ipl_start and ipl_clear are all 0.
- R2: In operating with the wait bit at 0 and no pending interruption, a stop key leaves state at 01 until the clock edge where uop_done is 1. After that edge, state is 00.
- R3: In operating with the wait bit at 1 and no pending interruption, a stop key makes state 00 at the next edge, without uop_done.
- R4: In operating, irq_take equals irq_pend. While irq_pend is 1, a stop request does not complete, even with uop_done at 1. The stop completes at the first qualifying edge after irq_pend falls.
- R5: With rate_step at 1, a start key in stopped gives state 01 with run_en at 1. State returns to 00 at the edge where uop_done is first 1.
- R6: With rate_step at 1 and the wait bit at 1, a start key gives state 01 with run_en at 0 and irq_take following irq_pend. State returns to 00 once irq_pend is 0, without any uop_done.
- R7: In stopped, run_en and irq_take stay 0 whatever irq_pend is.
- R8: reset_done makes state 00 from operating, stopped or check-stop. It is ignored in the load state (10).
- R9: addr_match in operating makes state 00 at the next edge.
- R10: In stopped, a start key (process mode) or restart_int makes state 01.
- R11: A load key makes state 10, with ipl_start at 1 for exactly the first cycle in that state. ipl_clear is 1 throughout the load state only for the load-clear key. ipl_done then gives 01 if rate_step is 0, or 00 if it is 1. Start and load keys are ignored while in 10.
- R12: malfunction makes state 11 from any state. In 11, stop, start and load keys have no effect, and only reset_done leaves it (to 00).
- R13: When several occur in the same cycle: malfunction beats a load key, a load key beats reset_done, and reset_done beats start or stop.
- R14: Keys act only on a rising edge. A key held high causes one action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_stop | input | 1 | Stop key level |
| key_start | input | 1 | Start key level |
| key_load_norm | input | 1 | Load-normal key level |
| key_load_clr | input | 1 | Load-clear key level |
| rate_step | input | 1 | 1 = instruction step, 0 = process |
| uop_done | input | 1 | Core finished a unit of operation this cycle |
| wait_bit | input | 1 | Wait-state bit of the current status word |
| irq_pend | input | 1 | An enabled interruption is pending |
| addr_match | input | 1 | Address compare hit with stop-on-match |
| reset_done | input | 1 | A reset sequence has completed |
| ipl_done | input | 1 | Initial program load completed successfully |
| restart_int | input | 1 | Restart interruption |
| malfunction | input | 1 | Machine malfunction detected |
| run_en | output | 1 | Core may execute instructions |
| irq_take | output | 1 | Core must take the pending interruption |
| ipl_start | output | 1 | One-cycle pulse that launches the program load |
| ipl_clear | output | 1 | Program load is of the clearing kind |
| state | output | 2 | 00 stopped, 01 operating, 10 load, 11 check-stop |

## Verification
The collisions of most interest put two causes of a state change in one clock cycle. Two cases are tested. In the first, a load key and a completed reset arrive together. In the second, a malfunction and a load key arrive together. The bench drives both inputs at the same falling edge. It then reads the state after the next rising edge, and the winner must match the priority order of R13. A third collision puts uop_done on the same cycles as a pending interruption during a stop. Here the state must stay operating until the interruption line falls.

// File: rtl/run_pkg.sv
package run_pkg;
    localparam int unsigned ST_W   = 2;
    localparam int unsigned N_KEYS = 4;

    localparam int unsigned K_STOP  = 0;
    localparam int unsigned K_START = 1;
    localparam int unsigned K_LDN   = 2;
    localparam int unsigned K_LDC   = 3;

    typedef enum logic [ST_W-1:0] {
        ST_STOP = 2'b00,
        ST_OPER = 2'b01,
        ST_LOAD = 2'b10,
        ST_CHK  = 2'b11
    } run_state_e;

    typedef struct packed {
        run_state_e st;
        logic       stop_pend;
        logic       ipl_go;
        logic       ipl_clr;
    } run_regs_t;
endpackage

// File: rtl/key_edge.sv
module key_edge #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_key
        logic prev_d;
        always_comb prev_d = lvl[i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= prev_d;
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/run_fsm.sv
module run_fsm
    import run_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_e,
    input  logic       start_e,
    input  logic       ldn_e,
    input  logic       ldc_e,
    input  logic       rate_step,
    input  logic       uop_done,
    input  logic       wait_bit,
    input  logic       irq_pend,
    input  logic       addr_match,
    input  logic       reset_done,
    input  logic       ipl_done,
    input  logic       restart_int,
    input  logic       malfunction,
    output run_regs_t  regs
);
    run_regs_t r_d, r_q;
    logic      ld_any;
    logic      stop_req;
    logic      stop_ok;

    always_comb begin
        ld_any   = ldn_e | ldc_e;
        stop_req = r_q.stop_pend | stop_e;
        stop_ok  = stop_req & ~irq_pend & (uop_done | wait_bit);

        r_d        = r_q;
        r_d.ipl_go = 1'b0;

        if (malfunction) begin
            r_d.st        = ST_CHK;
            r_d.stop_pend = 1'b0;
        end else if (r_q.st == ST_CHK) begin
            if (reset_done) r_d.st = ST_STOP;
        end else if (ld_any && r_q.st != ST_LOAD) begin
            r_d.st        = ST_LOAD;
            r_d.ipl_go    = 1'b1;
            r_d.ipl_clr   = ldc_e;
            r_d.stop_pend = 1'b0;
        end else if (reset_done && r_q.st != ST_LOAD) begin
            r_d.st        = ST_STOP;
            r_d.stop_pend = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_STOP: begin
                    if (start_e) begin
                        r_d.st        = ST_OPER;
                        r_d.stop_pend = rate_step;
                    end else if (restart_int) begin
                        r_d.st        = ST_OPER;
                        r_d.stop_pend = 1'b0;
                    end
                end
                ST_OPER: begin
                    if (addr_match || stop_ok) begin
                        r_d.st        = ST_STOP;
                        r_d.stop_pend = 1'b0;
                    end else begin
                        r_d.stop_pend = stop_req;
                    end
                end
                ST_LOAD: begin
                    if (ipl_done) begin
                        r_d.st        = rate_step ? ST_STOP : ST_OPER;
                        r_d.stop_pend = 1'b0;
                        r_d.ipl_clr   = 1'b0;
                    end
                end
                default: r_d.st = ST_CHK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_STOP;
            r_q.stop_pend <= 1'b0;
            r_q.ipl_go    <= 1'b0;
            r_q.ipl_clr   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;
endmodule

// File: rtl/run_out.sv
module run_out
    import run_pkg::*;
(
    input  run_regs_t        regs,
    input  logic             wait_bit,
    input  logic             irq_pend,
    output logic             run_en,
    output logic             irq_take,
    output logic             ipl_start,
    output logic             ipl_clear,
    output logic [ST_W-1:0]  state
);
    logic in_oper;
    logic in_load;

    always_comb begin
        in_oper   = (regs.st == ST_OPER);
        in_load   = (regs.st == ST_LOAD);
        run_en    = in_oper & ~wait_bit & ~irq_pend;
        irq_take  = in_oper & irq_pend;
        ipl_start = in_load & regs.ipl_go;
        ipl_clear = in_load & regs.ipl_clr;
        state     = regs.st;
    end
endmodule

// File: rtl/cpu_run_ctrl.sv
module cpu_run_ctrl
    import run_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            key_stop,
    input  logic            key_start,
    input  logic            key_load_norm,
    input  logic            key_load_clr,
    input  logic            rate_step,
    input  logic            uop_done,
    input  logic            wait_bit,
    input  logic            irq_pend,
    input  logic            addr_match,
    input  logic            reset_done,
    input  logic            ipl_done,
    input  logic            restart_int,
    input  logic            malfunction,
    output logic            run_en,
    output logic            irq_take,
    output logic            ipl_start,
    output logic            ipl_clear,
    output logic [ST_W-1:0] state
);
    logic [N_KEYS-1:0] key_lvl;
    logic [N_KEYS-1:0] key_rise;
    logic              ld_any;
    run_regs_t         regs;

    assign key_lvl[K_STOP]  = key_stop;
    assign key_lvl[K_START] = key_start;
    assign key_lvl[K_LDN]   = key_load_norm;
    assign key_lvl[K_LDC]   = key_load_clr;
    assign ld_any           = key_rise[K_LDN] | key_rise[K_LDC];

    key_edge #(.N(N_KEYS)) u_keys (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (key_lvl),
        .rise (key_rise)
    );

    run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_e     (key_rise[K_STOP]),
        .start_e    (key_rise[K_START]),
        .ldn_e      (key_rise[K_LDN]),
        .ldc_e      (key_rise[K_LDC]),
        .rate_step  (rate_step),
        .uop_done   (uop_done),
        .wait_bit   (wait_bit),
        .irq_pend   (irq_pend),
        .addr_match (addr_match),
        .reset_done (reset_done),
        .ipl_done   (ipl_done),
        .restart_int(restart_int),
        .malfunction(malfunction),
        .regs       (regs)
    );

    run_out u_out (
        .regs     (regs),
        .wait_bit (wait_bit),
        .irq_pend (irq_pend),
        .run_en   (run_en),
        .irq_take (irq_take),
        .ipl_start(ipl_start),
        .ipl_clear(ipl_clear),
        .state    (state)
    );
endmodule

// File: rtl/run_ctrl_chk.sv
module run_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state,
    input logic       run_en,
    input logic       irq_take,
    input logic       irq_pend,
    input logic       ipl_start,
    input logic       addr_match,
    input logic       reset_done,
    input logic       malfunction,
    input logic       ld_any
);
    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == 2'b00 |-> !run_en && !irq_take);

    // R4
    drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b01 && irq_pend && !addr_match && !reset_done) |=> state != 2'b00);

    // R12
    chk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        malfunction |=> state == 2'b11);

    // R12
    chk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b11 && !reset_done) |=> state == 2'b11);

    // R11
    ipl_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_start |-> state == 2'b10);

    // R11
    ipl_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_start |=> !ipl_start);

    // R9
    addr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b01 && addr_match && !malfunction && !ld_any) |=> state == 2'b00);
endmodule

bind cpu_run_ctrl run_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .run_en     (run_en),
    .irq_take   (irq_take),
    .irq_pend   (irq_pend),
    .ipl_start  (ipl_start),
    .addr_match (addr_match),
    .reset_done (reset_done),
    .malfunction(malfunction),
    .ld_any     (ld_any)
);

// File: tb/sim_cpu_run_ctrl.sv
module sim_cpu_run_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_stop = 0, key_start = 0, key_load_norm = 0, key_load_clr = 0;
    logic rate_step = 0, uop_done = 0, wait_bit = 0, irq_pend = 0;
    logic addr_match = 0, reset_done = 0, ipl_done = 0, restart_int = 0, malfunction = 0;
    logic run_en, irq_take, ipl_start, ipl_clear;
    logic [1:0] state;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cpu_run_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .key_stop(key_stop), .key_start(key_start),
        .key_load_norm(key_load_norm), .key_load_clr(key_load_clr),
        .rate_step(rate_step), .uop_done(uop_done), .wait_bit(wait_bit),
        .irq_pend(irq_pend), .addr_match(addr_match), .reset_done(reset_done),
        .ipl_done(ipl_done), .restart_int(restart_int), .malfunction(malfunction),
        .run_en(run_en), .irq_take(irq_take), .ipl_start(ipl_start),
        .ipl_clear(ipl_clear), .state(state)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // one clock with the given key raised, then released
    task automatic press_start(); key_start = 1; cyc(1); key_start = 0; endtask
    task automatic press_stop();  key_stop  = 1; cyc(1); key_stop  = 0; endtask

    task automatic to_stop();
        reset_done = 1; cyc(1); reset_done = 0;
    endtask

    task automatic go_oper();
        rate_step = 0; wait_bit = 0; irq_pend = 0;
        to_stop();
        press_start();
    endtask

    task automatic t_reset();
        check("R1 state in reset", state, 0);
        check("R1 run_en in reset", run_en, 0);
        cyc(1); rst_n = 1; cyc(1);
        check("R1 state after reset", state, 0);
        check("R1 outputs after reset", {run_en, irq_take, ipl_start, ipl_clear}, 0);
    endtask

    task automatic t_start_proc();
        to_stop(); rate_step = 0;
        press_start();
        check("R10 start gives operating", state, 1);
        check("R10 run_en in operating", run_en, 1);
        to_stop(); restart_int = 1; cyc(1); restart_int = 0;
        check("R10 restart gives operating", state, 1);
    endtask

    task automatic t_stop_uop();
        go_oper();
        press_stop();
        check("R2 no stop before uop", state, 1);
        cyc(2);
        check("R2 still operating", state, 1);
        uop_done = 1; cyc(1); uop_done = 0;
        check("R2 stopped at uop end", state, 0);
    endtask

    task automatic t_hold();
        to_stop(); rate_step = 0;
        key_start = 1; cyc(1);
        check("R14 held start enters operating", state, 1);
        addr_match = 1; cyc(1); addr_match = 0;
        cyc(2);
        check("R14 held start gives no second start", state, 0);
        key_start = 0; cyc(1);
    endtask

    task automatic t_wait_stop();
        go_oper(); wait_bit = 1;
        press_stop();
        check("R3 wait bit stops at once", state, 0);
        wait_bit = 0;
    endtask

    task automatic t_drain();
        go_oper();
        irq_pend = 1; uop_done = 1;
        press_stop();
        check("R4 held operating while pending", state, 1);
        check("R4 irq_take follows pending", irq_take, 1);
        cyc(1);
        check("R4 still operating", state, 1);
        irq_pend = 0; cyc(1);
        check("R4 stop after drain", state, 0);
        uop_done = 0;
    endtask

    task automatic t_stopped_irq();
        to_stop(); irq_pend = 1; cyc(2);
        check("R7 irq_take low in stopped", irq_take, 0);
        check("R7 run_en low in stopped", run_en, 0);
        check("R7 state stays stopped", state, 0);
        irq_pend = 0;
    endtask

    task automatic t_step();
        to_stop(); rate_step = 1; wait_bit = 0;
        press_start();
        check("R5 step start operating", state, 1);
        check("R5 step run_en", run_en, 1);
        cyc(1);
        check("R5 waits for unit", state, 1);
        uop_done = 1; cyc(1); uop_done = 0;
        check("R5 back to stopped", state, 0);
        rate_step = 0;
    endtask

    task automatic t_step_wait();
        to_stop(); rate_step = 1; wait_bit = 1; irq_pend = 1;
        press_start();
        check("R6 step wait operating", state, 1);
        check("R6 no execution", run_en, 0);
        check("R6 takes interruption", irq_take, 1);
        cyc(1);
        check("R6 stays while pending", state, 1);
        irq_pend = 0; cyc(1);
        check("R6 stopped after drain", state, 0);
        rate_step = 0; wait_bit = 0;
    endtask

    task automatic t_addr();
        go_oper();
        addr_match = 1; cyc(1); addr_match = 0;
        check("R9 address match stops", state, 0);
    endtask

    task automatic t_load();
        go_oper();
        key_load_norm = 1; cyc(1); key_load_norm = 0;
        check("R11 load state", state, 2);
        check("R11 ipl_start pulse", ipl_start, 1);
        check("R11 normal load not clearing", ipl_clear, 0);
        cyc(1);
        check("R11 ipl_start one cycle", ipl_start, 0);
        press_start();
        check("R11 start ignored in load", state, 2);
        reset_done = 1; cyc(1); reset_done = 0;
        check("R8 reset_done ignored in load", state, 2);
        rate_step = 0; ipl_done = 1; cyc(1); ipl_done = 0;
        check("R11 load done process", state, 1);
        key_load_clr = 1; cyc(1); key_load_clr = 0;
        check("R11 clear load flag", ipl_clear, 1);
        rate_step = 1; ipl_done = 1; cyc(1); ipl_done = 0;
        check("R11 load done step", state, 0);
        check("R11 clear flag drops", ipl_clear, 0);
        rate_step = 0;
    endtask

    task automatic t_chk();
        go_oper();
        malfunction = 1; cyc(1); malfunction = 0;
        check("R12 check-stop entered", state, 3);
        press_start();
        check("R12 start ignored", state, 3);
        press_stop();
        key_load_norm = 1; cyc(1); key_load_norm = 0;
        check("R12 load ignored", state, 3);
        check("R12 no ipl in check-stop", ipl_start, 0);
        reset_done = 1; cyc(1); reset_done = 0;
        check("R8 reset leaves check-stop", state, 0);
    endtask

    task automatic t_reset_done();
        go_oper();
        reset_done = 1; cyc(1); reset_done = 0;
        check("R8 reset_done from operating", state, 0);
    endtask

    task automatic t_prio();
        to_stop();
        malfunction = 1; key_load_norm = 1; cyc(1);
        malfunction = 0; key_load_norm = 0;
        check("R13 malfunction beats load", state, 3);
        to_stop();
        key_load_norm = 1; reset_done = 1; cyc(1);
        key_load_norm = 0; reset_done = 0;
        check("R13 load beats reset", state, 2);
        ipl_done = 1; cyc(1); ipl_done = 0;
        to_stop();
        key_start = 1; reset_done = 1; cyc(1);
        key_start = 0; reset_done = 0;
        check("R13 reset beats start", state, 0);
    endtask

    initial begin
        cyc(2);
        t_reset();
        t_start_proc();
        t_stop_uop();
        t_hold();
        t_wait_stop();
        t_drain();
        t_stopped_irq();
        t_step();
        t_step_wait();
        t_addr();
        t_load();
        t_chk();
        t_reset_done();
        t_prio();
        cyc(2);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule